// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the scan timing for a parallel RGB panel. Configuration arrives as plain inputs: four horizontal phase widths, four vertical phase widths, a pixel-clock divider, a launch-edge select, a clock-gating mode, one polarity bit per panel strobe and a vertical-compare selector. From these it drives horizontal and vertical sync, data-enable, a divided pixel clock, a line-end strobe, a one-cycle request per active pixel for an upstream pixel source, and a sticky vertical-compare interrupt.

The control is a run state machine with three named states. In `RS_IDLE` the outputs rest at their inactive levels. The transition IDLE->RUN is taken when `enable` is high, and the scan then starts from the first sync pixel of the first sync line. In `RS_RUN` the scan repeats frame after frame. The transition RUN->DRAIN is taken when `enable` drops. RUN->IDLE is taken directly when `enable` is low at the frame's final cycle. In `RS_DRAIN` the current frame completes. The transition DRAIN->RUN is taken if `enable` returns, and DRAIN->IDLE is taken at the final cycle of the frame.

Two copies of a four-state phase sequencer produce the scan. One runs horizontally and one runs vertically. Each steps through the states PH_SYNC->PH_BACK->PH_ACT->PH_FRONT->PH_SYNC. A phase moves to the next one when its counter reaches that phase's last value. The horizontal sequencer steps once per pixel. The vertical sequencer steps once per completed line.

Top module: `lcd_raster_gen`

## Requirements
- R1: A pixel lasts P = 2*(pclk_div+1) system clocks. A line lasts (hsync_w+1)+(hbp_w+1)+16*(hact_idx+1)+(hfp_w+1) pixels, so each frame's line-end count and total length follow from this.
- R2: Within a line the horizontal sync is active for (hsync_w+1)*P cycles per line. The phases run in the order sync, back porch, active, front porch.
- R3: A frame has (vsync_w+1)+(vbp_w+1)+(vact_n+1)+(vfp_w+1) lines in the order sync, back porch, active, front porch. The vertical sync is active for (vsync_w+1) whole lines. Data-enable is active only when both directions are in their active phase, for (vact_n+1)*16*(hact_idx+1)*P cycles per frame. It first asserts ((vsync_w+1)+(vbp_w+1)) lines plus ((hsync_w+1)+(hbp_w+1)) pixels after the frame starts.
- R4: For each of hsync, vsync, de and line_end, the polarity bit selects the active level: 0 gives active-low and 1 gives active-high.
- R5: With edge_fall=0 the pixel clock is high for the first half of every pixel, so it rises when the pixel data changes. With edge_fall=1 it is low for the first half, so it falls when the pixel data changes. Ungated, it spends exactly half of every frame away from the level edge_fall.
- R6: With pclk_gate=1 the pixel clock toggles only while data-enable is active. Outside that window it rests at the level edge_fall.
- R7: pix_req is a one-cycle pulse in the first system cycle of every active pixel, giving (vact_n+1)*16*(hact_idx+1) pulses per frame.
- R8: line_end is active for exactly one system cycle, the last cycle of every line.
- R9: A vertical-compare event fires in the first cycle of the vertical phase chosen by vcmp_sel (0 sync, 1 back porch, 2 active, 3 front porch). vcmp_pend is high from the next cycle on.
- R10: vcmp_pend is sticky. A vcmp_clr pulse clears it one cycle later, except that a new event in the same cycle wins. irq equals vcmp_pend AND vcmp_ie.
- R11: While in RS_IDLE with enable high, the next cycle is the first sync pixel of the first sync line. busy is high in RS_RUN and RS_DRAIN.
- R12: When enable is cleared, the frame in progress completes. The cycle after the frame's last cycle has busy low, every strobe at its inactive level and pclk at the level edge_fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Start / request stop of scanning |
| hsync_w | input | 8 | Horizontal sync width in pixels, minus one |
| hbp_w | input | 8 | Horizontal back porch in pixels, minus one |
| hact_idx | input | 8 | Active pixels per line = 16*(hact_idx+1) |
| hfp_w | input | 8 | Horizontal front porch in pixels, minus one |
| vsync_w | input | 8 | Vertical sync width in lines, minus one |
| vbp_w | input | 8 | Vertical back porch in lines, minus one |
| vact_n | input | 8 | Active lines, minus one |
| vfp_w | input | 8 | Vertical front porch in lines, minus one |
| pclk_div | input | 8 | Pixel period = 2*(pclk_div+1) system clocks |
| edge_fall | input | 1 | 0: data launched on pclk rise; 1: on pclk fall |
| pclk_gate | input | 1 | 0: free-running pclk; 1: pclk only during data-enable |
| hs_pol | input | 1 | hsync active level |
| vs_pol | input | 1 | vsync active level |
| de_pol | input | 1 | de active level |
| le_pol | input | 1 | line_end active level |
| vcmp_sel | input | 2 | Vertical phase that raises the compare event |
| vcmp_ie | input | 1 | Interrupt enable for the compare event |
| vcmp_clr | input | 1 | Write-one-to-clear pulse for vcmp_pend |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pclk | output | 1 | Pixel clock |
| line_end | output | 1 | One-cycle end-of-line strobe |
| pix_req | output | 1 | One-cycle request per active pixel (active high) |
| vcmp_pend | output | 1 | Sticky compare pending bit |
| irq | output | 1 | Gated interrupt |
| busy | output | 1 | Generator running |

## Verification
The strobes, pclk, pix_req and line_end are decoded combinationally from registered counters. They therefore show a new value in the same cycle as the clock edge that moves the counters. The first sync cycle appears one cycle after enable is sampled high in RS_IDLE. The bench counts frame cycles from the first falling clock edge after that enable edge. vcmp_pend and irq appear one cycle after their event, and a clear takes effect one cycle after the pulse. The bench predicts the exact cycle index for the first data-enable, the first interrupt and the drop of busy. It samples every output on the falling clock edge, half a period away from the edge that updates it.

// File: rtl/lrg_pkg.sv
package lrg_pkg;

    // Phase order is behaviour: sync, back porch, active, front porch.
    typedef enum logic [1:0] {
        PH_SYNC  = 2'd0,
        PH_BACK  = 2'd1,
        PH_ACT   = 2'd2,
        PH_FRONT = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_RUN   = 2'd1,
        RS_DRAIN = 2'd2
    } run_t;

endpackage

// File: rtl/lrg_pix_div.sv
module lrg_pix_div #(
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [FW-1:0] div,
    output logic          pix_first,
    output logic          pix_last,
    output logic          first_half
);
    localparam int PW = FW + 1;

    logic [PW-1:0] pcnt;
    logic [PW-1:0] plast;

    assign plast      = {div, 1'b1};
    assign pix_first  = (pcnt == '0);
    assign pix_last   = (pcnt == plast);
    assign first_half = (pcnt <= {1'b0, div});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pcnt <= '0;
        else if (clear || pix_last)
            pcnt <= '0;
        else
            pcnt <= pcnt + 1'b1;
    end

    // R5
    pcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt <= plast);

endmodule

// File: rtl/lrg_phase_seq.sv
module lrg_phase_seq
    import lrg_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                step,
    input  logic [3:0][CW-1:0]  last,
    output phase_t              ph,
    output logic [CW-1:0]       cnt,
    output logic                at_end
);
    phase_t        ph_nxt;
    logic [CW-1:0] cnt_nxt;
    logic          ph_done;

    assign ph_done = (cnt == last[ph]);
    assign at_end  = ph_done && (ph == PH_FRONT);

    always_comb begin
        ph_nxt  = ph;
        cnt_nxt = cnt;
        if (clear) begin
            ph_nxt  = PH_SYNC;
            cnt_nxt = '0;
        end else if (step) begin
            if (ph_done) begin
                cnt_nxt = '0;
                unique case (ph)
                    PH_SYNC:  ph_nxt = PH_BACK;
                    PH_BACK:  ph_nxt = PH_ACT;
                    PH_ACT:   ph_nxt = PH_FRONT;
                    PH_FRONT: ph_nxt = PH_SYNC;
                endcase
            end else begin
                cnt_nxt = cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph  <= PH_SYNC;
            cnt <= '0;
        end else begin
            ph  <= ph_nxt;
            cnt <= cnt_nxt;
        end
    end

    // R2
    ph_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear) |=> ($stable(ph) && $stable(cnt)));

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last[ph]);

endmodule

// File: rtl/lrg_run_ctl.sv
module lrg_run_ctl
    import lrg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic frame_end,
    output run_t state,
    output logic busy
);
    run_t state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            RS_IDLE:  if (en) state_nxt = RS_RUN;
            RS_RUN: begin
                if (!en && frame_end) state_nxt = RS_IDLE;
                else if (!en)         state_nxt = RS_DRAIN;
            end
            RS_DRAIN: begin
                if (en)             state_nxt = RS_RUN;
                else if (frame_end) state_nxt = RS_IDLE;
            end
            default:  state_nxt = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RS_IDLE;
        else        state <= state_nxt;
    end

    assign busy = (state != RS_IDLE);

    // R11
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RS_IDLE && en) |=> (state == RS_RUN));

    // R12
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RS_DRAIN && !en && !frame_end) |=> (state == RS_DRAIN));

endmodule

// File: rtl/lcd_raster_gen.sv
module lcd_raster_gen
    import lrg_pkg::*;
#(
    parameter int FW       = 8,
    parameter int PIX_STEP = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [FW-1:0] hsync_w,
    input  logic [FW-1:0] hbp_w,
    input  logic [FW-1:0] hact_idx,
    input  logic [FW-1:0] hfp_w,
    input  logic [FW-1:0] vsync_w,
    input  logic [FW-1:0] vbp_w,
    input  logic [FW-1:0] vact_n,
    input  logic [FW-1:0] vfp_w,
    input  logic [FW-1:0] pclk_div,
    input  logic          edge_fall,
    input  logic          pclk_gate,
    input  logic          hs_pol,
    input  logic          vs_pol,
    input  logic          de_pol,
    input  logic          le_pol,
    input  logic [1:0]    vcmp_sel,
    input  logic          vcmp_ie,
    input  logic          vcmp_clr,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic          pclk,
    output logic          line_end,
    output logic          pix_req,
    output logic          vcmp_pend,
    output logic          irq,
    output logic          busy
);
    localparam int CW = FW + $clog2(PIX_STEP);

    run_t             state;
    logic             run;
    logic             clear;
    logic             pix_first, pix_last, first_half;
    phase_t           h_ph, v_ph;
    logic [CW-1:0]    h_cnt, v_cnt;
    logic             h_end, v_end;
    logic             h_wrap, frame_end;
    logic [3:0][CW-1:0] h_last, v_last;
    logic [CW-1:0]    act_last;
    logic             hs_act, vs_act, de_act, le_act;
    logic             evt;

    assign run   = (state != RS_IDLE);
    assign clear = !run;

    assign act_last = (CW'(hact_idx) + CW'(1)) * CW'(PIX_STEP) - CW'(1);
    assign h_last   = {CW'(hfp_w), act_last, CW'(hbp_w), CW'(hsync_w)};
    assign v_last   = {CW'(vfp_w), CW'(vact_n), CW'(vbp_w), CW'(vsync_w)};

    lrg_pix_div #(.FW(FW)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .div        (pclk_div),
        .pix_first  (pix_first),
        .pix_last   (pix_last),
        .first_half (first_half)
    );

    lrg_phase_seq #(.CW(CW)) u_hseq (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .step   (pix_last),
        .last   (h_last),
        .ph     (h_ph),
        .cnt    (h_cnt),
        .at_end (h_end)
    );

    assign h_wrap    = run && pix_last && h_end;
    assign frame_end = h_wrap && v_end;

    lrg_phase_seq #(.CW(CW)) u_vseq (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .step   (h_wrap),
        .last   (v_last),
        .ph     (v_ph),
        .cnt    (v_cnt),
        .at_end (v_end)
    );

    lrg_run_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (enable),
        .frame_end (frame_end),
        .state     (state),
        .busy      (busy)
    );

    // Output decode: every strobe parks inactive outside a running scan.
    always_comb begin
        hs_act   = run && (h_ph == PH_SYNC);
        vs_act   = run && (v_ph == PH_SYNC);
        de_act   = run && (h_ph == PH_ACT) && (v_ph == PH_ACT);
        le_act   = h_wrap;
        hsync    = hs_pol ? hs_act : !hs_act;
        vsync    = vs_pol ? vs_act : !vs_act;
        de       = de_pol ? de_act : !de_act;
        line_end = le_pol ? le_act : !le_act;
        pix_req  = de_act && pix_first;
        if (!run || (pclk_gate && !de_act))
            pclk = edge_fall;
        else
            pclk = first_half ^ edge_fall;
    end

    assign evt = run && (v_ph == phase_t'(vcmp_sel)) && (v_cnt == '0) &&
                 (h_ph == PH_SYNC) && (h_cnt == '0) && pix_first;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        vcmp_pend <= 1'b0;
        else if (evt)      vcmp_pend <= 1'b1;
        else if (vcmp_clr) vcmp_pend <= 1'b0;
    end

    assign irq = vcmp_pend && vcmp_ie;

    // R3
    de_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de_act |-> (!hs_act && !vs_act));

    // R9
    evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> vcmp_pend);

    // R10
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vcmp_clr && !evt) |=> !vcmp_pend);

    // R7
    req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_req |-> (de_act && !$isunknown(pclk)));

    // R12
    park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!hs_act && !vs_act && !de_act && (pclk == edge_fall)));

endmodule

// File: tb/tb_lcd_raster_gen.sv
`timescale 1ns/1ps
module tb_lcd_raster_gen;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic       enable = 1'b0;
    logic [7:0] hsync_w = 8'd0, hbp_w = 8'd0, hact_idx = 8'd0, hfp_w = 8'd0;
    logic [7:0] vsync_w = 8'd0, vbp_w = 8'd0, vact_n = 8'd0, vfp_w = 8'd0;
    logic [7:0] pclk_div = 8'd0;
    logic       edge_fall = 1'b0, pclk_gate = 1'b0;
    logic       hs_pol = 1'b1, vs_pol = 1'b1, de_pol = 1'b1, le_pol = 1'b1;
    logic [1:0] vcmp_sel = 2'd0;
    logic       vcmp_ie = 1'b0, vcmp_clr = 1'b0;
    logic       hsync, vsync, de, pclk, line_end, pix_req, vcmp_pend, irq, busy;

    lcd_raster_gen dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .hsync_w(hsync_w), .hbp_w(hbp_w), .hact_idx(hact_idx), .hfp_w(hfp_w),
        .vsync_w(vsync_w), .vbp_w(vbp_w), .vact_n(vact_n), .vfp_w(vfp_w),
        .pclk_div(pclk_div), .edge_fall(edge_fall), .pclk_gate(pclk_gate),
        .hs_pol(hs_pol), .vs_pol(vs_pol), .de_pol(de_pol), .le_pol(le_pol),
        .vcmp_sel(vcmp_sel), .vcmp_ie(vcmp_ie), .vcmp_clr(vcmp_clr),
        .hsync(hsync), .vsync(vsync), .de(de), .pclk(pclk),
        .line_end(line_end), .pix_req(pix_req), .vcmp_pend(vcmp_pend),
        .irq(irq), .busy(busy)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R11 watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state: parked
        chk(busy == 1'b0, "R12 reset busy", busy, 0);
        chk(hsync == !hs_pol && vsync == !vs_pol && de == !de_pol, "R4 reset strobes", {hsync, vsync, de}, 0);
        chk(pclk == edge_fall && irq == 1'b0, "R12 reset pclk/irq", {pclk, irq}, {edge_fall, 1'b0});

        for (int k = 0; k < 8; k++) begin
            int hs, hb, ix, hf, vs, vb, va, vf, dv, P, lpix, lines, F, act_px;
            int ph_start, exp_first_irq, exp_de_first;
            int n_hs, n_vs, n_de, n_req, n_le, n_pk, n_irq, irq_first, de_first;
            bit c0_hs, c0_vs, c0_pk, busy_pre, hold_clr;
            logic [3:0] pol;

            hs = k % 3; hb = (k + 1) % 3; ix = k % 2; hf = (k / 2) % 3;
            vs = k % 2; vb = (k / 2) % 2; va = k % 3; vf = (k + 1) % 2;
            dv = k % 3;
            pol = 4'((k * 5) % 16);
            hold_clr = (k == 5);
            hsync_w = 8'(hs); hbp_w = 8'(hb); hact_idx = 8'(ix); hfp_w = 8'(hf);
            vsync_w = 8'(vs); vbp_w = 8'(vb); vact_n = 8'(va); vfp_w = 8'(vf);
            pclk_div = 8'(dv);
            edge_fall = k[0]; pclk_gate = k[1];
            hs_pol = pol[0]; vs_pol = pol[1]; de_pol = pol[2]; le_pol = pol[3];
            vcmp_sel = 2'(k % 4); vcmp_ie = 1'b1;

            P = 2 * (dv + 1);
            act_px = 16 * (ix + 1);
            lpix = (hs + 1) + (hb + 1) + act_px + (hf + 1);
            lines = (vs + 1) + (vb + 1) + (va + 1) + (vf + 1);
            F = lines * lpix * P;
            case (k % 4)
                0: ph_start = 0;
                1: ph_start = vs + 1;
                2: ph_start = (vs + 1) + (vb + 1);
                default: ph_start = (vs + 1) + (vb + 1) + (va + 1);
            endcase
            exp_first_irq = ph_start * lpix * P + 1;
            exp_de_first = ((vs + 1) + (vb + 1)) * lpix * P + ((hs + 1) + (hb + 1)) * P;

            // clear any stale pending while idle
            vcmp_clr = 1'b1;
            @(negedge clk);
            vcmp_clr = hold_clr;
            enable = 1'b1;

            n_hs = 0; n_vs = 0; n_de = 0; n_req = 0; n_le = 0; n_pk = 0; n_irq = 0;
            irq_first = -1; de_first = -1; c0_hs = 0; c0_vs = 0; c0_pk = 0; busy_pre = 0;

            for (int c = 0; c <= F; c++) begin
                @(negedge clk);
                if (c < F) begin
                    if (c == 0) begin
                        c0_hs = (hsync == hs_pol);
                        c0_vs = (vsync == vs_pol);
                        c0_pk = pclk;
                    end
                    n_hs  += (hsync == hs_pol);
                    n_vs  += (vsync == vs_pol);
                    n_le  += (line_end == le_pol);
                    n_req += pix_req;
                    n_pk  += (pclk != edge_fall);
                    if (de == de_pol) begin
                        n_de++;
                        if (de_first < 0) de_first = c;
                    end
                    if (irq) begin
                        n_irq++;
                        if (irq_first < 0) irq_first = c;
                    end
                end
                if (c == F - 1) busy_pre = busy;
                if (c == F / 2) enable = 1'b0;
            end

            // R11 first cycle is sync of sync line
            chk(c0_hs && c0_vs, "R11 start in sync", {c0_hs, c0_vs}, 3);
            // R2 hsync width per line
            chk(n_hs == lines * (hs + 1) * P, "R2 hsync cycles", n_hs, lines * (hs + 1) * P);
            // R3 vsync lines, de count and position
            chk(n_vs == (vs + 1) * lpix * P, "R3 vsync cycles", n_vs, (vs + 1) * lpix * P);
            chk(n_de == (va + 1) * act_px * P, "R3 de cycles", n_de, (va + 1) * act_px * P);
            chk(de_first == exp_de_first, "R3 first de", de_first, exp_de_first);
            // R7 requests per frame
            chk(n_req == (va + 1) * act_px, "R7 pix_req pulses", n_req, (va + 1) * act_px);
            // R8 and R1 line_end count = lines per frame
            chk(n_le == lines, "R8 line_end cycles", n_le, lines);
            // R5 / R6 pixel clock
            if (pclk_gate) begin
                chk(n_pk == n_de / 2, "R6 gated pclk", n_pk, n_de / 2);
                chk(c0_pk == edge_fall, "R6 pclk rest", c0_pk, edge_fall);
            end else begin
                chk(n_pk == F / 2, "R5 pclk duty", n_pk, F / 2);
                chk(c0_pk == !edge_fall, "R5 launch edge", c0_pk, !edge_fall);
            end
            // R9 event position
            chk(irq_first == exp_first_irq, "R9 irq first", irq_first, exp_first_irq);
            // R10 sticky vs clear held
            if (hold_clr)
                chk(n_irq == 1, "R10 set beats clear", n_irq, 1);
            else
                chk(n_irq == F - exp_first_irq, "R10 sticky irq", n_irq, F - exp_first_irq);
            // R1 frame length and R12 park after finishing the frame
            chk(busy_pre == 1'b1, "R1 busy last frame cycle", busy_pre, 1);
            chk(busy == 1'b0, "R12 idle after frame", busy, 0);
            chk(hsync == !hs_pol && vsync == !vs_pol && de == !de_pol && line_end == !le_pol,
                "R4 parked levels", {hsync, vsync, de, line_end}, {!hs_pol, !vs_pol, !de_pol, !le_pol});
            chk(pclk == edge_fall, "R12 pclk parked", pclk, edge_fall);

            vcmp_clr = 1'b0;
            if (!hold_clr) begin
                vcmp_ie = 1'b0;
                @(negedge clk);
                // R10 irq masked while pending
                chk(vcmp_pend == 1'b1 && irq == 1'b0, "R10 mask", {vcmp_pend, irq}, 2);
                vcmp_clr = 1'b1;
                @(negedge clk);
                vcmp_clr = 1'b0;
                chk(vcmp_pend == 1'b0, "R10 clear", vcmp_pend, 0);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule